// File: doc/BRIEF.md
# Sixteen-bit execute unit with flag generation

This block is the execute stage of a small 16-bit processor. It takes an operation code, two register operands, a 4-bit immediate field and the current carry flag. It produces a 16-bit result, new negative, carry and zero flags, a mask that says which flags the operation writes, and a strobe that says whether the result is written back. It covers addition, addition with carry, negation, compare, the bitwise logic operations, the register and immediate shifts, and the expansion of the 4-bit immediate into a full operand.

The operation logic is combinational. A single output register captures it, so results appear one clock after the operands are presented. Register file access, memory and control flow stay in the surrounding core. A flag whose mask bit is clear still appears on its output pin: an operation that does not write carry passes the incoming carry through unchanged.

Top module: `exec_alu`

## Requirements
- R1: While `rst_n` is low, every output is zero, including both write masks.
- R2: ADD (0), NEG (2) and CMP (3) form a 17-bit result. Z is set when bits 15:0 are zero, N is bit 15 and C is bit 16. The flag mask is 3'b111, where bit 2 is N, bit 1 is C and bit 0 is Z. NEG computes 0 − a.
- R3: ADC (1) adds `carry_i` to a + b. Its flags follow R2.
- R4: CMP (3) outputs a − b with `res_we_o` low. Every other opcode drives `res_we_o` high.
- R5: AND (4), OR (5), XOR (6) and NOT (7, which gives ~a) write only N and Z, with mask 3'b101. `flag_c_o` equals `carry_i`. ANDI (12) and ORI (13) behave the same way.
- R6: ANDI and ORI combine a with the immediate sign-extended from its bit 3.
- R7: ADDI (11) adds the immediate to a, sign-extended from bit 3, except that the code 0 stands for +8. Its flags follow R2.
- R8: SHI (14) shifts a by imm[2:0] places, where 0 stands for 8. imm[3]=1 selects a logical right shift and imm[3]=0 a left shift. A left shift puts operand bit (16 − n) into C. A right shift puts bit (n − 1) into C. The mask is 3'b111.
- R9: SHL (8), SHR (9) and SAR (10) shift a by b. For 1 ≤ b ≤ 15, a right shift puts operand bit (b − 1) into C and a left shift puts bit (16 − b) into C. A zero shift returns a unchanged with C = 0.
- R10: SAR and SARI (15) fill with copies of bit 15. For SARI the amount is the immediate, and the code 0 stands for 16. That amount yields all sign bits, with C taken from operand bit 15.
- R11: A register shift amount of 16 or more gives 0 for SHL and SHR, and all sign bits for SAR. C is 0 in each of these cases.
- R12: The outputs change only on the rising clock edge. They reflect the inputs sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 16 | First operand (a) |
| opb_i | input | 16 | Second operand or register shift amount (b) |
| imm_i | input | 4 | Immediate field |
| carry_i | input | 1 | Current carry flag |
| res_o | output | 16 | Result |
| res_we_o | output | 1 | Result is to be written back |
| flag_n_o | output | 1 | Negative flag |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |
| flag_we_o | output | 3 | Flag write mask {N, C, Z} |

## Verification
The hardest cases to reach are the carry bits of the shifts, where the captured bit depends on the direction and on the encoded amount. Among them, a register amount of 16 must return carry 0, while the immediate arithmetic shift whose code 0 also means 16 returns bit 15. The vector table pairs these cases on operands chosen so that the bit that should be captured differs from its neighbours. Amounts of 16, 20 and 256 are driven to prove the upper operand bits are decoded. Operands such as 0xFFFF + 1 and 0 − 1 push a set bit into position 16 so that the carry and zero rules show.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

    localparam int DATA_W = 16;
    localparam int IMM_W  = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_NEG  = 4'd2,
        OP_CMP  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_SHL  = 4'd8,
        OP_SHR  = 4'd9,
        OP_SAR  = 4'd10,
        OP_ADDI = 4'd11,
        OP_ANDI = 4'd12,
        OP_ORI  = 4'd13,
        OP_SHI  = 4'd14,
        OP_SARI = 4'd15
    } alu_op_e;

    // flag mask layout {N, C, Z}
    localparam logic [2:0] MASK_NCZ = 3'b111;
    localparam logic [2:0] MASK_NZ  = 3'b101;

    function automatic logic is_bitwise(input logic [3:0] op);
        return op inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ANDI, OP_ORI};
    endfunction

endpackage

// File: rtl/exec_alu_imm.sv
module exec_alu_imm #(
    parameter int WIDTH = 16,
    parameter int IMM_W = 4,
    parameter int SW    = 5
) (
    input  logic [IMM_W-1:0] imm_i,
    output logic [WIDTH-1:0] logic_imm_o,
    output logic [WIDTH-1:0] add_imm_o,
    output logic [SW-1:0]    small_amt_o,
    output logic             small_right_o,
    output logic [SW-1:0]    sar_amt_o
);
    localparam int SMALL_BITS = IMM_W - 1;
    localparam int SMALL_ZERO = 1 << SMALL_BITS;
    localparam int SAR_ZERO   = 1 << IMM_W;

    always_comb begin
        logic_imm_o = {{(WIDTH-IMM_W){imm_i[IMM_W-1]}}, imm_i};
        if (imm_i == '0) begin
            add_imm_o = WIDTH'(SMALL_ZERO);
        end else begin
            add_imm_o = logic_imm_o;
        end

        small_right_o = imm_i[IMM_W-1];
        if (imm_i[SMALL_BITS-1:0] == '0) begin
            small_amt_o = SW'(SMALL_ZERO);
        end else begin
            small_amt_o = SW'(imm_i[SMALL_BITS-1:0]);
        end

        if (imm_i == '0) begin
            sar_amt_o = SW'(SAR_ZERO);
        end else begin
            sar_amt_o = SW'(imm_i);
        end
    end
endmodule

// File: rtl/exec_alu_shift.sv
module exec_alu_shift #(
    parameter int WIDTH = 16,
    parameter int SW    = 5
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [SW-1:0]    amt_i,
    input  logic             right_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);
    localparam int EXT_W = 2 * WIDTH;

    logic [EXT_W-1:0] left_ext;
    logic [EXT_W-1:0] right_base;
    logic [EXT_W-1:0] right_ext;

    always_comb begin
        left_ext   = {{WIDTH{1'b0}}, a_i} << amt_i;
        right_base = {a_i, {WIDTH{1'b0}}};
        if (arith_i) begin
            right_ext = EXT_W'($signed(right_base) >>> amt_i);
        end else begin
            right_ext = right_base >> amt_i;
        end

        if (right_i) begin
            res_o  = right_ext[EXT_W-1:WIDTH];
            cout_o = right_ext[WIDTH-1];
        end else begin
            res_o  = left_ext[WIDTH-1:0];
            cout_o = left_ext[WIDTH];
        end
    end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_alu_pkg::*;
#(
    parameter int WIDTH = exec_alu_pkg::DATA_W,
    parameter int IMM_W = exec_alu_pkg::IMM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] res_o,
    output logic             res_we_o,
    output logic             flag_n_o,
    output logic             flag_c_o,
    output logic             flag_z_o,
    output logic [2:0]       flag_we_o
);
    // shift amount width able to hold WIDTH itself (WIDTH a power of two)
    localparam int SW = $clog2(WIDTH) + 1;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             rwe;
        logic             n;
        logic             c;
        logic             z;
        logic [2:0]       we;
    } stage_t;

    stage_t out_d, out_q;

    logic [WIDTH-1:0] logic_imm, add_imm;
    logic [SW-1:0]    small_amt, sar_amt;
    logic             small_right;

    exec_alu_imm #(.WIDTH(WIDTH), .IMM_W(IMM_W), .SW(SW)) u_imm (
        .imm_i         (imm_i),
        .logic_imm_o   (logic_imm),
        .add_imm_o     (add_imm),
        .small_amt_o   (small_amt),
        .small_right_o (small_right),
        .sar_amt_o     (sar_amt)
    );

    logic [SW-1:0]    sh_amt;
    logic             sh_right, sh_arith;
    logic [WIDTH-1:0] sh_res;
    logic             sh_cout;
    logic             b_wide;

    assign b_wide = |opb_i[WIDTH-1:SW-1];

    always_comb begin
        sh_right = 1'b0;
        sh_arith = 1'b0;
        sh_amt   = opb_i[SW-1:0];
        unique case (alu_op_e'(op_i))
            OP_SHR:  sh_right = 1'b1;
            OP_SAR:  begin sh_right = 1'b1; sh_arith = 1'b1; end
            OP_SHI:  begin sh_right = small_right; sh_amt = small_amt; end
            OP_SARI: begin sh_right = 1'b1; sh_arith = 1'b1; sh_amt = sar_amt; end
            default: ;
        endcase
        if (b_wide && (op_i == OP_SHL || op_i == OP_SHR || op_i == OP_SAR)) begin
            sh_amt = SW'(WIDTH);
        end
    end

    exec_alu_shift #(.WIDTH(WIDTH), .SW(SW)) u_shift (
        .a_i     (opa_i),
        .amt_i   (sh_amt),
        .right_i (sh_right),
        .arith_i (sh_arith),
        .res_o   (sh_res),
        .cout_o  (sh_cout)
    );

    logic [WIDTH:0] wide;

    always_comb begin
        wide   = '0;
        out_d  = '0;
        out_d.rwe = 1'b1;
        out_d.we  = MASK_NCZ;
        unique case (alu_op_e'(op_i))
            OP_ADD:  wide = {1'b0, opa_i} + {1'b0, opb_i};
            OP_ADC:  wide = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, carry_i};
            OP_NEG:  wide = {(WIDTH+1){1'b0}} - {1'b0, opa_i};
            OP_CMP:  begin
                wide      = {1'b0, opa_i} - {1'b0, opb_i};
                out_d.rwe = 1'b0;
            end
            OP_ADDI: wide = {1'b0, opa_i} + {1'b0, add_imm};
            OP_AND:  wide = {1'b0, opa_i & opb_i};
            OP_OR:   wide = {1'b0, opa_i | opb_i};
            OP_XOR:  wide = {1'b0, opa_i ^ opb_i};
            OP_NOT:  wide = {1'b0, ~opa_i};
            OP_ANDI: wide = {1'b0, opa_i & logic_imm};
            OP_ORI:  wide = {1'b0, opa_i | logic_imm};
            OP_SHL, OP_SHR, OP_SAR: begin
                wide = {sh_cout & ~b_wide, sh_res};
            end
            OP_SHI, OP_SARI: wide = {sh_cout, sh_res};
            default: wide = '0;
        endcase

        out_d.res = wide[WIDTH-1:0];
        out_d.z   = (wide[WIDTH-1:0] == '0);
        out_d.n   = wide[WIDTH-1];
        if (is_bitwise(op_i)) begin
            out_d.c  = carry_i;
            out_d.we = MASK_NZ;
        end else begin
            out_d.c  = wide[WIDTH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_o     = out_q.res;
    assign res_we_o  = out_q.rwe;
    assign flag_n_o  = out_q.n;
    assign flag_c_o  = out_q.c;
    assign flag_z_o  = out_q.z;
    assign flag_we_o = out_q.we;

    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flag_z_o == (res_o == '0)));

    // R2
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (flag_n_o == res_o[WIDTH-1]));

    // R4
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == OP_CMP) |-> !res_we_o);

    // R5
    bitwise_carry_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && is_bitwise($past(op_i)))
            |-> (flag_c_o == $past(carry_i)) && (flag_we_o == MASK_NZ));

    // R11
    wide_logical_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == OP_SHL || $past(op_i) == OP_SHR)
            && $past(|opb_i[WIDTH-1:SW-1])) |-> (res_o == '0) && !flag_c_o);

endmodule

// File: tb/exec_alu_test.sv
module exec_alu_test;
    import exec_alu_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [15:0] opa_i = '0;
    logic [15:0] opb_i = '0;
    logic [3:0]  imm_i = '0;
    logic        carry_i = 1'b0;
    logic [15:0] res_o;
    logic        res_we_o, flag_n_o, flag_c_o, flag_z_o;
    logic [2:0]  flag_we_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    exec_alu uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
        .imm_i(imm_i), .carry_i(carry_i), .res_o(res_o), .res_we_o(res_we_o),
        .flag_n_o(flag_n_o), .flag_c_o(flag_c_o), .flag_z_o(flag_z_o),
        .flag_we_o(flag_we_o)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic [3:0]  imm;
        logic        cin;
        logic [15:0] res;
        logic        rwe;
        logic [2:0]  ncz;
        logic [2:0]  we;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{OP_ADD,  16'h7FFF, 16'h0001, 4'h0, 1'b0, 16'h8000, 1'b1, 3'b100, 3'b111, 4'd2},  // R2
        '{OP_ADD,  16'hFFFF, 16'h0001, 4'h0, 1'b0, 16'h0000, 1'b1, 3'b011, 3'b111, 4'd2},  // R2
        '{OP_ADC,  16'h0001, 16'h0001, 4'h0, 1'b1, 16'h0003, 1'b1, 3'b000, 3'b111, 4'd3},  // R3
        '{OP_NEG,  16'h0001, 16'h0000, 4'h0, 1'b0, 16'hFFFF, 1'b1, 3'b110, 3'b111, 4'd2},  // R2
        '{OP_NEG,  16'h0000, 16'h0000, 4'h0, 1'b1, 16'h0000, 1'b1, 3'b001, 3'b111, 4'd2},  // R2
        '{OP_CMP,  16'h0005, 16'h0005, 4'h0, 1'b0, 16'h0000, 1'b0, 3'b001, 3'b111, 4'd4},  // R4
        '{OP_CMP,  16'h0003, 16'h0005, 4'h0, 1'b0, 16'hFFFE, 1'b0, 3'b110, 3'b111, 4'd4},  // R4
        '{OP_AND,  16'hF0F0, 16'h0FF0, 4'h0, 1'b1, 16'h00F0, 1'b1, 3'b010, 3'b101, 4'd5},  // R5
        '{OP_XOR,  16'hAAAA, 16'hAAAA, 4'h0, 1'b0, 16'h0000, 1'b1, 3'b001, 3'b101, 4'd5},  // R5
        '{OP_NOT,  16'h00FF, 16'h0000, 4'h0, 1'b1, 16'hFF00, 1'b1, 3'b110, 3'b101, 4'd5},  // R5
        '{OP_ANDI, 16'h1234, 16'h0000, 4'h8, 1'b0, 16'h1230, 1'b1, 3'b000, 3'b101, 4'd6},  // R6
        '{OP_ORI,  16'h0000, 16'hFFFF, 4'h7, 1'b1, 16'h0007, 1'b1, 3'b010, 3'b101, 4'd6},  // R6
        '{OP_ADDI, 16'h0010, 16'h0000, 4'h0, 1'b0, 16'h0018, 1'b1, 3'b000, 3'b111, 4'd7},  // R7
        '{OP_ADDI, 16'h0010, 16'h0000, 4'hF, 1'b0, 16'h000F, 1'b1, 3'b010, 3'b111, 4'd7},  // R7
        '{OP_SHI,  16'h8001, 16'h0000, 4'h1, 1'b0, 16'h0002, 1'b1, 3'b010, 3'b111, 4'd8},  // R8
        '{OP_SHI,  16'h1280, 16'h0000, 4'h8, 1'b0, 16'h0012, 1'b1, 3'b010, 3'b111, 4'd8},  // R8
        '{OP_SHI,  16'h00AB, 16'h0000, 4'h0, 1'b1, 16'hAB00, 1'b1, 3'b100, 3'b111, 4'd8},  // R8
        '{OP_SHR,  16'h0003, 16'h0001, 4'h0, 1'b0, 16'h0001, 1'b1, 3'b010, 3'b111, 4'd9},  // R9
        '{OP_SHR,  16'h8000, 16'h0000, 4'h0, 1'b1, 16'h8000, 1'b1, 3'b100, 3'b111, 4'd9},  // R9
        '{OP_SHL,  16'h4001, 16'h0002, 4'h0, 1'b0, 16'h0004, 1'b1, 3'b010, 3'b111, 4'd9},  // R9
        '{OP_SAR,  16'h8004, 16'h0003, 4'h0, 1'b0, 16'hF000, 1'b1, 3'b110, 3'b111, 4'd10}, // R10
        '{OP_SARI, 16'h8000, 16'h0000, 4'h0, 1'b0, 16'hFFFF, 1'b1, 3'b110, 3'b111, 4'd10}, // R10
        '{OP_SARI, 16'h7FF8, 16'h0000, 4'h4, 1'b0, 16'h07FF, 1'b1, 3'b010, 3'b111, 4'd10}, // R10
        '{OP_SHL,  16'hFFFF, 16'h0010, 4'h0, 1'b1, 16'h0000, 1'b1, 3'b001, 3'b111, 4'd11}, // R11
        '{OP_SAR,  16'h8001, 16'h0100, 4'h0, 1'b1, 16'hFFFF, 1'b1, 3'b100, 3'b111, 4'd11}, // R11
        '{OP_SHR,  16'hFFFF, 16'h0014, 4'h0, 1'b1, 16'h0000, 1'b1, 3'b001, 3'b111, 4'd11}  // R11
    };

    function automatic logic [22:0] observed();
        return {res_o, res_we_o, flag_n_o, flag_c_o, flag_z_o, flag_we_o};
    endfunction

    task automatic check(input string tag, input logic [22:0] got, input logic [22:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [3:0] imm, input logic cin);
        op_i = op; opa_i = a; opb_i = b; imm_i = imm; carry_i = cin;
    endtask

    initial begin
        // R1: outputs cleared during reset
        repeat (3) @(negedge clk);
        check("R1 reset", observed(), 23'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].imm, VECS[i].cin);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), observed(),
                  {VECS[i].res, VECS[i].rwe, VECS[i].ncz, VECS[i].we});
        end

        // R12: new inputs do not reach the outputs before the next edge
        drive(OP_ADD, 16'h0001, 16'h0001, 4'h0, 1'b0);
        @(negedge clk);
        drive(OP_ADD, 16'h0005, 16'h0005, 4'h0, 1'b0);
        #2;
        check("R12 hold", observed(), {16'h0002, 1'b1, 3'b000, 3'b111});
        @(negedge clk);
        check("R12 update", observed(), {16'h000A, 1'b1, 3'b000, 3'b111});

        // R5: OR keeps an incoming carry of 0 after an op that set C
        drive(OP_ADD, 16'hFFFF, 16'h0002, 4'h0, 1'b0);
        @(negedge clk);
        drive(OP_OR, 16'h8000, 16'h0001, 4'h0, 1'b0);
        @(negedge clk);
        check("R5 or carry", observed(), {16'h8001, 1'b1, 3'b100, 3'b101});

        // R1: reset in mid-run clears at once
        rst_n = 1'b0;
        #2;
        check("R1 mid reset", observed(), 23'h0);
        @(negedge clk);
        check("R1 reset held", observed(), 23'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule